// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the device side of a small byte-wide nonvolatile memory on a four-wire serial bus. The host lowers chip select and then clocks in an 8-bit instruction, most significant bit first. The instruction may be followed by a 16-bit address and data bytes, or the block may answer with data bytes. Six instructions are recognised. Two of them set or clear the write-enable latch. The others read the status byte, write the status byte, read the array and write the array.

Every change to stored content needs the write-enable latch to be set first. The latch clears itself whenever a modifying instruction completes. Bytes received by an array write are held in a page buffer. They are committed during an internal write cycle that begins when chip select rises. While that cycle runs, the status byte reports busy and every instruction other than a status read is ignored.

The serial pins are sampled by the system clock. The serial clock must therefore run well below it.

Top module: `spi_eeprom_slave`

## Requirements
- R1: An instruction byte is valid only when its upper nibble is 0000. Bit 3 is ignored, and bits 2:0 select the instruction: 110 set latch, 100 clear latch, 101 read status, 001 write status, 011 read array, 010 write array. Any other byte drives nothing on the output and changes no state.
- R2: After reset the status byte reads 0x00: latch clear, not busy, protection fields zero.
- R3: The set-latch and clear-latch instructions take effect when chip select rises after exactly 8 bits. A complete clear-latch, write-status or write-array instruction leaves the latch cleared.
- R4: Input bits are taken on rising serial clock edges and output bits change on falling edges. Every field is sent most significant bit first.
- R5: Status read returns {wpen, 000, bp[1:0], wel, busy} (bit 7 down to bit 0), and repeats it for every further byte clocked.
- R6: With the latch set, a complete status write copies data bit 7 to wpen and data bits 3:2 to bp, and ignores the other bits. It also starts a write cycle.
- R7: Array read takes a 16-bit address of which only the low 12 bits select a byte. It returns successive bytes, with the address wrapping from 0xFFF to 0x000.
- R8: Array write buffers its data bytes inside one PAGE_BYTES-aligned page, wrapping to the page start. After at least one whole data byte, the bytes are committed when chip select rises, provided the latch is set.
- R9: A status or array write ended after an incomplete address or data field is discarded and leaves the latch unchanged. A set-latch or clear-latch instruction with extra bits is also discarded.
- R10: A write cycle keeps busy high for WR_CYCLES system clocks. During that time only status read is accepted, and all other instructions leave state and output unchanged.
- R11: so_en is low while chip select is high and outside status or array data output.
- R12: Status or array writes issued while the latch is clear change no stored content and start no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host, valid while so_en is high |
| so_en | output | 1 | Output enable for the tri-state driver of so |

## Verification
A wrong bit counter or phase shows at the ports on the very first read after the command: the returned bytes arrive shifted, or so_en stays low. A latch that is stuck or wrongly set shows in bit 1 of the next status read, and shows again on a later readback where a write landed that should not have. A lost or misplaced page buffer entry is invisible until the write cycle ends, so every committed write is followed by polling busy and then reading the page back against a byte-level model.

// File: rtl/spi_eeprom_slave.sv
`timescale 1ns/1ps
module spi_eeprom_slave #(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 1000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_en
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {
    PH_OPC, PH_LATCH, PH_ADDR, PH_WDAT, PH_RDAT, PH_STAT, PH_WSR, PH_DEAD
  } ph_t;

  logic s_cs, p_cs, s_sck, p_sck, s_si;
  ph_t ph;
  logic [3:0] cnt;
  logic [15:0] sh;
  logic lset, op_wr, full;
  logic [AW-1:0] ab;
  logic [7:0] ob;
  logic [2:0] ocnt;
  logic so_r, wel, wpen;
  logic [1:0] bp;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] cp;
  logic [AW-PW-1:0] wpg;
  logic [PW-1:0] widx;
  logic [PAGE_BYTES-1:0] wmask;
  logic [7:0] wbuf [PAGE_BYTES];
  logic [7:0] mem [MEM_BYTES];

  wire [15:0] sh_n = {sh[14:0], s_si};
  wire [AW-1:0] ab_n = ab + AW'(1);
  wire sck_rise = !s_cs && s_sck && !p_sck;
  wire sck_fall = !s_cs && !s_sck && p_sck;
  wire cs_rise = s_cs && !p_cs;
  wire busy = bcnt != '0;
  wire commit = !cp[PW];
  wire [7:0] status = {wpen, 3'b000, bp, wel, busy};
  wire go_wr = (ph == PH_WDAT) && full && wel;
  wire go_sr = (ph == PH_WSR) && full && wel;
  wire out_ph = (ph == PH_STAT) || (ph == PH_RDAT);

  assign so = so_r;
  assign so_en = !s_cs && out_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs <= 1'b1; p_cs <= 1'b1; s_sck <= 1'b0; p_sck <= 1'b0; s_si <= 1'b0;
      ph <= PH_OPC; cnt <= '0; sh <= '0;
      lset <= 1'b0; op_wr <= 1'b0; full <= 1'b0;
      ab <= '0; ob <= '0; ocnt <= '0; so_r <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0;
      bcnt <= '0; cp <= {1'b1, {PW{1'b0}}};
      wpg <= '0; widx <= '0; wmask <= '0;
    end else begin
      s_cs <= cs_n; p_cs <= s_cs;
      s_sck <= sck; p_sck <= s_sck;
      s_si <= si;
      if (busy) bcnt <= bcnt - BW'(1);
      if (commit) cp <= cp + CW'(1);
      if (cs_rise) begin
        ph <= PH_OPC;
        cnt <= '0;
        full <= 1'b0;
        if (ph == PH_LATCH) wel <= lset;
        if ((ph == PH_WSR || ph == PH_WDAT) && full) wel <= 1'b0;
        if (go_sr) begin
          wpen <= sh[7];
          bp <= sh[3:2];
        end
        if (go_sr || go_wr) begin
          bcnt <= BW'(WR_CYCLES);
          cp <= '0;
        end
        if (!busy && !go_wr) wmask <= '0;
      end else if (sck_rise) begin
        case (ph)
          PH_OPC: begin
            sh <= sh_n;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0;
              if (sh_n[7:4] != 4'd0 || (busy && sh_n[2:0] != 3'b101)) ph <= PH_DEAD;
              else begin
                case (sh_n[2:0])
                  3'b110: begin ph <= PH_LATCH; lset <= 1'b1; end
                  3'b100: begin ph <= PH_LATCH; lset <= 1'b0; end
                  3'b101: begin ph <= PH_STAT; ob <= status; ocnt <= '0; end
                  3'b001: ph <= PH_WSR;
                  3'b011: begin ph <= PH_ADDR; op_wr <= 1'b0; end
                  3'b010: begin ph <= PH_ADDR; op_wr <= 1'b1; end
                  default: ph <= PH_DEAD;
                endcase
              end
            end
          end
          PH_LATCH: ph <= PH_DEAD;
          PH_WSR: begin
            sh <= sh_n;
            cnt <= cnt + 4'd1;
            if (full) ph <= PH_DEAD;
            else if (cnt == 4'd7) begin
              full <= 1'b1;
              cnt <= '0;
            end
          end
          PH_ADDR: begin
            sh <= sh_n;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              if (op_wr) begin
                ph <= PH_WDAT;
                {wpg, widx} <= sh_n[AW-1:0];
                wmask <= '0;
              end else begin
                ph <= PH_RDAT;
                ab <= sh_n[AW-1:0];
                ob <= mem[sh_n[AW-1:0]];
                ocnt <= '0;
              end
            end
          end
          PH_WDAT: begin
            sh <= sh_n;
            full <= (cnt == 4'd7);
            cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
            if (cnt == 4'd7) begin
              widx <= widx + PW'(1);
              if (wel) wmask[widx] <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (sck_fall && out_ph) begin
        so_r <= ob[7];
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd7) begin
          if (ph == PH_RDAT) begin
            ob <= mem[ab_n];
            ab <= ab_n;
          end else ob <= status;
        end else ob <= {ob[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sck_rise && ph == PH_WDAT && cnt == 4'd7) wbuf[widx] <= sh_n[7:0];
    if (commit && wmask[cp[PW-1:0]]) mem[{wpg, cp[PW-1:0]}] <= wbuf[cp[PW-1:0]];
  end
endmodule

module spi_eeprom_slave_chk #(
  parameter int WR_CYCLES = 1000
)(
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so_en,
  input logic busy,
  input logic wel,
  input logic [2:0] prot
);
  int blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blen <= 0;
    else blen <= busy ? blen + 1 : 0;
  end

  AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) ($past(cs_n) && cs_n) |-> !so_en); // R11
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> blen == WR_CYCLES); // R10
  AST_WEL_DROPS_AT_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !wel); // R3
  AST_WEL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> !$rose(wel)); // R10
  AST_PROT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) (prot != $past(prot)) |-> $past(wel)); // R6
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en),
  .busy(busy), .wel(wel), .prot({wpen, bp})
);

// File: tb/test_spi_eeprom_slave.sv
`timescale 1ns/1ps
module test_spi_eeprom_slave;
  localparam int H = 2;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_en;
  always #2.5 clk = ~clk;

  spi_eeprom_slave i_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_en(so_en)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, seen_oe = 0;
  logic [7:0] emem [4096];
  bit known [4096];
  bit m_wel = 0, m_wpen = 0;
  logic [1:0] m_bp = 2'b00;
  logic [7:0] wdat [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 195000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] exp_st(input bit b);
    return {m_wpen, 3'b000, m_bp, m_wel, b};
  endfunction

  function automatic logic [7:0] opc(input logic [2:0] c);
    return {4'b0000, 1'($urandom % 2), c};
  endfunction

  task automatic xbit(input logic b, output logic o, output logic oe);
    @(negedge clk); sck = 1'b0; si = b;
    repeat (H) @(negedge clk);
    o = so; oe = so_en; sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) begin
      xbit(v[i], o, oe);
      if (oe) seen_oe = 1;
    end
  endtask

  task automatic get_byte(output logic [7:0] v, output bit alloe);
    logic o, oe;
    alloe = 1;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b0, o, oe);
      v[i] = o;
      if (!oe) alloe = 0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_st(output logic [7:0] st, output bit oe);
    cs_lo();
    send_bits({8'h00, opc(3'b101)}, 8);
    get_byte(st, oe);
    cs_hi();
  endtask

  task automatic check_st(input string req);
    logic [7:0] st; bit oe;
    rd_st(st, oe);
    chk(oe && st == exp_st(0), req, {oe, st}, {1'b1, exp_st(0)});
  endtask

  task automatic wait_ready(input bit first_busy);
    logic [7:0] st; bit oe;
    rd_st(st, oe);
    if (first_busy) chk(oe && st == exp_st(1), "R10", {oe, st}, {1'b1, exp_st(1)});
    for (int k = 0; k < 40 && st[0]; k++) rd_st(st, oe);
    chk(oe && st == exp_st(0), "R10", {oe, st}, {1'b1, exp_st(0)});
  endtask

  task automatic do_simple(input logic [7:0] op, input int extra);
    cs_lo();
    send_bits({8'h00, op}, 8);
    if (extra > 0) send_bits(16'h0000, extra);
    cs_hi();
  endtask

  task automatic do_wren(); do_simple(opc(3'b110), 0); m_wel = 1; endtask
  task automatic do_wrdi(); do_simple(opc(3'b100), 0); m_wel = 0; endtask

  task automatic do_wrsr(input logic [7:0] v, input int nb);
    cs_lo();
    send_bits({8'h00, opc(3'b001)}, 8);
    send_bits({8'h00, v} >> (8 - nb), nb);
    cs_hi();
    if (nb == 8) begin
      if (m_wel) begin
        m_wel = 0; m_wpen = v[7]; m_bp = v[3:2];
        wait_ready(1);
      end
      m_wel = 0;
    end
  endtask

  task automatic do_write(input logic [15:0] a, input int abits, input int n, input int extra, input bit wait_it);
    int base, pg, idx;
    cs_lo();
    send_bits({8'h00, opc(3'b010)}, 8);
    send_bits(a >> (16 - abits), abits);
    if (abits == 16) begin
      for (int i = 0; i < n; i++) send_bits({8'h00, wdat[i]}, 8);
      if (extra > 0) send_bits(16'h0000, extra);
    end
    cs_hi();
    if (abits == 16 && extra == 0 && n >= 1) begin
      if (m_wel) begin
        base = int'(a[11:0]); pg = base & ~31; idx = base & 31;
        for (int i = 0; i < n; i++) begin
          emem[pg | idx] = wdat[i]; known[pg | idx] = 1;
          idx = (idx + 1) & 31;
        end
        m_wel = 0;
        if (wait_it) wait_ready(1);
      end
      m_wel = 0;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic [7:0] v; bit oe; int ad;
    cs_lo();
    send_bits({8'h00, opc(3'b011)}, 8);
    send_bits(a, 16);
    for (int i = 0; i < n; i++) begin
      get_byte(v, oe);
      ad = (int'(a[11:0]) + i) & 12'hFFF;
      chk(oe && (!known[ad] || v == emem[ad]), req, {oe, v}, {1'b1, emem[ad]});
    end
    cs_hi();
  endtask

  initial begin
    logic [7:0] st, v; bit oe;
    int kind, n;
    logic [15:0] a;
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    chk(so_en == 1'b0, "R11", so_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    seen_oe = 0;
    rd_st(st, oe);
    chk(oe && st == 8'h00, "R2", st, 0);
    chk(!seen_oe, "R11", seen_oe, 0);
    chk(so_en == 1'b0, "R11", so_en, 0);

    do_wren(); check_st("R3");
    do_wrdi(); check_st("R3");
    do_simple(8'h0E, 1); check_st("R9");
    do_simple(8'h0E, 0); m_wel = 1; check_st("R1");
    do_simple(8'h16, 0); do_wrdi(); do_simple(8'h16, 0); check_st("R1");

    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    do_wren(); do_write(16'h0100, 16, 3, 0, 1); check_st("R3");
    do_read(16'h0100, 3, "R4");
    wdat[0] = 8'hAA; wdat[1] = 8'hBB; wdat[2] = 8'hCC;
    do_write(16'h0100, 16, 3, 0, 0); check_st("R12");
    do_read(16'h0100, 3, "R12");

    do_wren(); do_wrsr(8'hFF, 8);
    rd_st(st, oe); chk(st == 8'h8C, "R6", st, 8'h8C);
    do_wrsr(8'h00, 8); check_st("R12");
    rd_st(st, oe); chk(st == 8'h8C, "R12", st, 8'h8C);
    do_wren(); do_wrsr(8'h70, 8);
    rd_st(st, oe); chk(st == 8'h00, "R6", st, 0);

    cs_lo(); send_bits({8'h00, opc(3'b101)}, 8);
    for (int i = 0; i < 3; i++) begin
      get_byte(v, oe); chk(oe && v == exp_st(0), "R5", v, exp_st(0));
    end
    cs_hi();

    wdat[0] = 8'hA1; wdat[1] = 8'hA2;
    do_wren(); do_write(16'h0FFE, 16, 2, 0, 1);
    wdat[0] = 8'hB0;
    do_wren(); do_write(16'h7000, 16, 1, 0, 1);
    do_read(16'hFFFE, 3, "R7");
    do_read(16'h5100, 2, "R7");

    wdat[0] = 8'hC1; wdat[1] = 8'hC2; wdat[2] = 8'hC3;
    do_wren(); do_write(16'h023E, 16, 3, 0, 1);
    do_read(16'h0220, 1, "R8");
    do_read(16'h023E, 2, "R8");

    wdat[0] = 8'h5A;
    do_wren(); do_write(16'h0300, 16, 1, 0, 1);
    wdat[0] = 8'hE7;
    do_wren(); do_write(16'h0300, 16, 1, 3, 1); check_st("R9");
    do_write(16'h0300, 10, 0, 0, 1); check_st("R9");
    do_write(16'h0300, 16, 0, 0, 1); check_st("R9");
    do_wrsr(8'hFF, 5); check_st("R9");
    do_read(16'h0300, 1, "R9");
    do_wrdi();

    for (int i = 0; i < 4; i++) wdat[i] = 8'h40 + 8'(i);
    do_wren(); do_write(16'h0400, 16, 4, 0, 0);
    do_simple(opc(3'b110), 0);
    seen_oe = 0;
    cs_lo(); send_bits({8'h00, opc(3'b011)}, 8); send_bits(16'h0400, 16); send_bits(16'h0000, 8); cs_hi();
    chk(!seen_oe, "R10", seen_oe, 0);
    rd_st(st, oe); chk(oe && st == exp_st(1), "R10", st, exp_st(1));
    wait_ready(0);
    do_read(16'h0400, 4, "R10");

    seen_oe = 0;
    do_simple(8'h07, 16); do_simple(8'h00, 8); do_simple(8'h20 | opc(3'b101), 8);
    chk(!seen_oe, "R1", seen_oe, 0);
    check_st("R1");

    for (int t = 0; t < 50; t++) begin
      kind = int'($urandom % 9);
      a = 16'($urandom);
      if ($urandom % 4 == 0) a[11:0] = 12'hFE0 | 12'($urandom % 32);
      case (kind)
        0: begin do_wren(); check_st("R3"); end
        1: begin do_wrdi(); check_st("R3"); end
        2: begin do_wrsr(8'($urandom), 8); check_st("R6"); end
        3, 4: begin
          n = 1 + int'($urandom % 20);
          for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
          if ($urandom % 4 != 0) do_wren();
          do_write(a, 16, n, 0, 1); check_st("R8");
        end
        5, 6: do_read(a, 1 + int'($urandom % 6), "R7");
        7: begin
          n = 1 + int'($urandom % 4);
          for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
          do_wren();
          do_write(a, 16, n, 1 + int'($urandom % 7), 1); check_st("R9");
        end
        default: begin
          v = 8'($urandom);
          if (v[7:4] == 4'd0) v[2:0] = (v[0]) ? 3'b111 : 3'b000;
          seen_oe = 0;
          do_simple(v, 16);
          chk(!seen_oe, "R1", seen_oe, 0);
          check_st("R1");
        end
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule